// File: doc/BRIEF.md
# Two-Byte Auto-Increment Flash Program Sequencer

This block writes a run of bytes into a serial NOR flash that lacks a page program command and instead offers a single-byte program plus an auto-address-increment mode that stores two bytes per command. It accepts a start address, a byte length and a ready/valid byte stream. It drives a byte-level SPI master. That master exchanges one byte per request and raises chip select from the first request of a command until the byte flagged as last is acknowledged.

The sequence has fixed rules. An unaligned first byte goes out with a byte program. Aligned pairs go out through the auto-increment command: only its first frame carries the address, and later frames carry the opcode and two data bytes. A write disable closes the auto-increment mode. A leftover byte at the end gets its own write enable, byte program and write disable. Before the sequence starts and after every program frame, the device status is polled until its busy bit clears. A poll that stays busy too long aborts the run with an error. When the run ends, the block pulses `done` and reports the number of data bytes it sent.

Top module: `wordprog_seq`

## Requirements
- R1: After `start`, the first command is a status poll. A length of zero ends the run with `done` after that poll, with no other command and a byte count of 0.
- R2: Once the first poll shows the device idle and the length is non-zero, a write enable (single byte 0x06) is sent.
- R3: For an odd start address, one byte goes out first as opcode 0x02, the address bytes most significant first, then one data byte. A status poll follows.
- R4: Pairs use opcode 0xAD followed by two data bytes. The first such frame puts the address (most significant byte first) between the opcode and the data. Later frames carry no address, and the address advances by two per pair.
- R5: A status poll is the two-byte frame 0x05, 0x00. Bit 0 of the byte received during the second byte means busy, and the poll repeats while it is 1. A poll follows every program frame and every first-stage write disable.
- R6: After the last pair, or directly after the write enable or odd head when no pair exists, a write disable (single byte 0x04) is sent and then polled.
- R7: If one byte remains after that, the block sends a write enable, then 0x02 with the byte's address and the byte, then a poll, then 0x04, and the run ends.
- R8: If POLL_LIMIT consecutive polls all read busy, the run stops at once with `done` and `error` both high, and no further byte is requested.
- R9: `byteCount` equals the number of data bytes sent, and `done` is a single-cycle pulse while `busy` is low.
- R10: `spiLast` is high exactly on the final byte of each command. A request is held until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; accepted while idle |
| startAddr | input | 8*ADDR_BYTES | First byte address |
| startLen | input | LEN_W | Number of bytes to write |
| inByte | input | 8 | Data byte stream |
| inValid | input | 1 | inByte is valid |
| inReady | output | 1 | inByte consumed this cycle |
| spiReq | output | 1 | Byte exchange request to SPI master |
| spiTx | output | 8 | Byte to send |
| spiLast | output | 1 | Last byte of the command; release chip select after it |
| spiAck | input | 1 | Master finished the exchange |
| spiRx | input | 8 | Byte received during the exchange |
| busy | output | 1 | A run is active |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Run ended on poll timeout |
| byteCount | output | LEN_W | Data bytes sent in the current or last run |

## Verification
The hardest situation to reach is a poll timeout in the middle of a run, after data has already been committed. The device must stay busy past the first program frame, and the bench must then show that nothing further is requested and that the count stops at the bytes already sent. A behavioural flash model in the bench answers every poll. A per-test mode makes it go permanently busy either from the start or right after the first program frame, so both abort points are exercised. The same model releases busy after a fixed number of polls in normal runs, which makes the expected byte stream exact.

// File: rtl/wordprog_pkg.sv
package wordprog_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_BP   = 8'h02;
  localparam logic [7:0] OP_AAI  = 8'hAD;

  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL, ST_WREN, ST_BP, ST_AAI, ST_WRDI
  } seqStateT;

  typedef enum logic [1:0] {
    PRIOR_INIT, PRIOR_PROG, PRIOR_WRDI
  } priorT;

  typedef enum logic [1:0] {
    SEL_OP, SEL_ADDR, SEL_DATA
  } txSelT;

  typedef struct packed {
    logic       load;
    logic       dataTaken;
    logic       pollClr;
    logic       pollInc;
    txSelT      sel;
    logic [7:0] op;
  } ctlStrobeT;
endpackage

// File: rtl/wordprog_datapath.sv
module wordprog_datapath
  import wordprog_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int LEN_W      = 16,
  parameter int POLL_LIMIT = 1024,
  parameter int IDX_W      = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobeT               ctl,
  input  logic [IDX_W-1:0]        idx,
  input  logic [8*ADDR_BYTES-1:0] startAddr,
  input  logic [LEN_W-1:0]        startLen,
  input  logic [7:0]              inByte,
  output logic [7:0]              spiTx,
  output logic                    addrOdd,
  output logic                    remZero,
  output logic                    remOne,
  output logic                    remGe2,
  output logic                    pollLast,
  output logic [LEN_W-1:0]        byteCount
);
  localparam int AW     = 8 * ADDR_BYTES;
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  logic [AW-1:0]     addr;
  logic [LEN_W-1:0]  rem;
  logic [LEN_W-1:0]  cnt;
  logic [POLL_W-1:0] pollCnt;
  logic [7:0]        addrByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr    <= '0;
      rem     <= '0;
      cnt     <= '0;
      pollCnt <= '0;
    end else begin
      if (ctl.load) begin
        addr <= startAddr;
        rem  <= startLen;
        cnt  <= '0;
      end else if (ctl.dataTaken) begin
        addr <= addr + AW'(1);
        rem  <= rem - LEN_W'(1);
        cnt  <= cnt + LEN_W'(1);
      end
      if (ctl.pollClr)      pollCnt <= '0;
      else if (ctl.pollInc) pollCnt <= pollCnt + POLL_W'(1);
    end
  end

  // address bytes leave most significant first: idx 1 selects the top byte
  always_comb begin
    addrByte = 8'h00;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (idx == IDX_W'(ADDR_BYTES - k)) addrByte = addr[8*k +: 8];
    end
  end

  always_comb begin
    case (ctl.sel)
      SEL_ADDR: spiTx = addrByte;
      SEL_DATA: spiTx = inByte;
      default:  spiTx = ctl.op;
    endcase
  end

  assign addrOdd   = addr[0];
  assign remZero   = (rem == '0);
  assign remOne    = (rem == LEN_W'(1));
  assign remGe2    = (rem > LEN_W'(1));
  assign pollLast  = (pollCnt == POLL_W'(POLL_LIMIT - 1));
  assign byteCount = cnt;

  // R9: a data byte is never taken beyond the requested length
  p_no_overrun_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dataTaken |-> !remZero);

  // R8: the busy poll counter never reaches the limit
  p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < POLL_W'(POLL_LIMIT));
endmodule

// File: rtl/wordprog_control.sv
module wordprog_control
  import wordprog_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             inValid,
  output logic             inReady,
  output logic             spiReq,
  output logic             spiLast,
  input  logic             spiAck,
  input  logic [7:0]       spiRx,
  input  logic             addrOdd,
  input  logic             remZero,
  input  logic             remOne,
  input  logic             remGe2,
  input  logic             pollLast,
  output ctlStrobeT        ctl,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done,
  output logic             error
);
  localparam logic [IDX_W-1:0] AB_I = IDX_W'(ADDR_BYTES);
  localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);
  localparam logic [IDX_W-1:0] TWO  = IDX_W'(2);

  seqStateT         state;
  priorT            prior;
  logic             tailMode;
  logic             aaiStarted;
  logic             doneQ;
  logic             errQ;
  logic [IDX_W-1:0] lastIdx;
  logic             isData;
  logic             fire;
  logic             frameEnd;
  logic             pollBusy;
  seqStateT         pairNext;
  logic             unusedRx;

  assign unusedRx = ^spiRx[7:1];
  assign pollBusy = spiRx[0];

  always_comb begin
    lastIdx = '0;
    isData  = 1'b0;
    ctl.sel = SEL_OP;
    ctl.op  = 8'h00;
    case (state)
      ST_POLL: begin lastIdx = ONE; ctl.op = (idx == '0) ? OP_RDSR : 8'h00; end
      ST_WREN: ctl.op = OP_WREN;
      ST_WRDI: ctl.op = OP_WRDI;
      ST_BP:   begin lastIdx = AB_I + ONE; ctl.op = OP_BP; end
      ST_AAI:  begin lastIdx = aaiStarted ? TWO : AB_I + TWO; ctl.op = OP_AAI; end
      default: ;
    endcase
    if (state == ST_BP || (state == ST_AAI && !aaiStarted)) begin
      if (idx != '0 && idx <= AB_I) ctl.sel = SEL_ADDR;
      else if (idx > AB_I) begin ctl.sel = SEL_DATA; isData = 1'b1; end
    end else if (state == ST_AAI && idx != '0) begin
      ctl.sel = SEL_DATA;
      isData  = 1'b1;
    end
  end

  assign spiReq   = (state != ST_IDLE) && (!isData || inValid);
  assign spiLast  = (state != ST_IDLE) && (idx == lastIdx);
  assign fire     = spiReq && spiAck;
  assign frameEnd = fire && (idx == lastIdx);
  assign inReady  = fire && isData;
  assign pairNext = remGe2 ? ST_AAI : ST_WRDI;

  assign ctl.load      = start && (state == ST_IDLE);
  assign ctl.dataTaken = inReady;
  assign ctl.pollInc   = frameEnd && (state == ST_POLL) && pollBusy && !pollLast;
  assign ctl.pollClr   = ctl.load || (frameEnd && (state == ST_POLL) && !pollBusy);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      prior      <= PRIOR_INIT;
      tailMode   <= 1'b0;
      aaiStarted <= 1'b0;
      idx        <= '0;
      doneQ      <= 1'b0;
      errQ       <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (ctl.load) begin
        state      <= ST_POLL;
        prior      <= PRIOR_INIT;
        tailMode   <= 1'b0;
        aaiStarted <= 1'b0;
        idx        <= '0;
        errQ       <= 1'b0;
      end else if (fire) begin
        if (!frameEnd) begin
          idx <= idx + ONE;
        end else begin
          idx <= '0;
          case (state)
            ST_POLL: begin
              if (pollBusy) begin
                if (pollLast) begin
                  state <= ST_IDLE; doneQ <= 1'b1; errQ <= 1'b1;
                end
              end else begin
                case (prior)
                  PRIOR_INIT: if (remZero) begin state <= ST_IDLE; doneQ <= 1'b1; end
                              else state <= ST_WREN;
                  PRIOR_PROG: state <= tailMode ? ST_WRDI : pairNext;
                  default:    if (remOne) begin state <= ST_WREN; tailMode <= 1'b1; end
                              else begin state <= ST_IDLE; doneQ <= 1'b1; end
                endcase
              end
            end
            ST_WREN: state <= (tailMode || addrOdd) ? ST_BP : pairNext;
            ST_BP:   begin state <= ST_POLL; prior <= PRIOR_PROG; end
            ST_AAI:  begin state <= ST_POLL; prior <= PRIOR_PROG; aaiStarted <= 1'b1; end
            ST_WRDI: if (tailMode) begin state <= ST_IDLE; doneQ <= 1'b1; end
                     else begin state <= ST_POLL; prior <= PRIOR_WRDI; end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign busy  = (state != ST_IDLE);
  assign done  = doneQ;
  assign error = errQ;

  // R10: a command byte request stays up until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (spiReq && !spiAck && !isData) |=> spiReq);

  // R9: the end pulse comes with no outstanding request
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!spiReq && !busy));

  // R8: an error only appears together with the end pulse
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> done);

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/wordprog_seq.sv
module wordprog_seq
  import wordprog_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int LEN_W      = 16,
  parameter int POLL_LIMIT = 1024
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [8*ADDR_BYTES-1:0] startAddr,
  input  logic [LEN_W-1:0]        startLen,
  input  logic [7:0]              inByte,
  input  logic                    inValid,
  output logic                    inReady,
  output logic                    spiReq,
  output logic [7:0]              spiTx,
  output logic                    spiLast,
  input  logic                    spiAck,
  input  logic [7:0]              spiRx,
  output logic                    busy,
  output logic                    done,
  output logic                    error,
  output logic [LEN_W-1:0]        byteCount
);
  localparam int IDX_W = $clog2(ADDR_BYTES + 3);

  ctlStrobeT        ctl;
  logic [IDX_W-1:0] idx;
  logic             addrOdd, remZero, remOne, remGe2, pollLast;

  wordprog_control #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_control (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .inReady(inReady),
    .spiReq(spiReq), .spiLast(spiLast), .spiAck(spiAck), .spiRx(spiRx),
    .addrOdd(addrOdd), .remZero(remZero), .remOne(remOne), .remGe2(remGe2),
    .pollLast(pollLast), .ctl(ctl), .idx(idx), .busy(busy), .done(done),
    .error(error)
  );

  wordprog_datapath #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W),
                      .POLL_LIMIT(POLL_LIMIT), .IDX_W(IDX_W)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .idx(idx), .startAddr(startAddr),
    .startLen(startLen), .inByte(inByte), .spiTx(spiTx), .addrOdd(addrOdd),
    .remZero(remZero), .remOne(remOne), .remGe2(remGe2), .pollLast(pollLast),
    .byteCount(byteCount)
  );
endmodule

// File: tb/test_wordprog_seq.sv
`timescale 1ns/100ps
module test_wordprog_seq;
  localparam int LIMIT = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] startAddr = '0;
  logic [15:0] startLen = '0;
  logic [7:0]  inByte = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        spiReq;
  logic [7:0]  spiTx;
  logic        spiLast;
  logic        spiAck = 1'b0;
  logic [7:0]  spiRx = '0;
  logic        busy, done, error;
  logic [15:0] byteCount;

  int checks = 0;
  int fails = 0;
  logic [8:0] expQ[$];
  int expCount;
  bit expErr;
  string curTag;

  // flash model state
  int k = 0;
  bit advPending = 0;
  int fIdx = 0;
  logic [7:0] fOp = '0;
  int busyLeft = 0;
  bit stuck = 0;
  int stuckMode = 0;

  always #2.5 clk = ~clk;

  wordprog_seq #(.ADDR_BYTES(3), .LEN_W(16), .POLL_LIMIT(LIMIT)) i_wordprog_seq (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .startLen(startLen), .inByte(inByte), .inValid(inValid), .inReady(inReady),
    .spiReq(spiReq), .spiTx(spiTx), .spiLast(spiLast), .spiAck(spiAck),
    .spiRx(spiRx), .busy(busy), .done(done), .error(error), .byteCount(byteCount)
  );

  function automatic logic [7:0] dataAt(int i);
    return 8'(8'hA0 + i * 7);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic pushB(bit last, logic [7:0] b);
    expQ.push_back({last, b});
  endtask

  task automatic pushPolls(int n);
    for (int j = 0; j < n; j++) begin pushB(0, 8'h05); pushB(1, 8'h00); end
  endtask

  task automatic pushAddr(int a);
    for (int s = 2; s >= 0; s--) pushB(0, 8'(a >> (8 * s)));
  endtask

  // expected command stream built from the requirements (R1..R8)
  task automatic buildExp(int a0, int len, int mode);
    int a, r, i;
    bit first;
    a = a0; r = len; i = 0; first = 1;
    expQ.delete(); expErr = 0; expCount = 0;
    if (mode == 1) begin pushPolls(LIMIT); expErr = 1; return; end
    pushPolls(1);                                   // R1
    if (len == 0) return;
    pushB(1, 8'h06);                                // R2
    if (a % 2 != 0) begin                           // R3
      pushB(0, 8'h02); pushAddr(a); pushB(1, dataAt(i));
      i++; a++; r--; expCount = i;
      if (mode == 2) begin pushPolls(LIMIT); expErr = 1; return; end
      pushPolls(3);
    end
    while (r >= 2) begin                            // R4
      pushB(0, 8'hAD);
      if (first) pushAddr(a);
      pushB(0, dataAt(i)); pushB(1, dataAt(i + 1));
      i += 2; a += 2; r -= 2; first = 0;
      pushPolls(3);                                 // R5
    end
    pushB(1, 8'h04); pushPolls(3);                  // R6
    if (r == 1) begin                               // R7
      pushB(1, 8'h06); pushB(0, 8'h02); pushAddr(a); pushB(1, dataAt(i));
      i++; pushPolls(3); pushB(1, 8'h04);
    end
    expCount = i;
  endtask

  // flash model + monitor: acknowledges each byte and compares it with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (advPending) begin k++; inByte = dataAt(k); advPending = 0; end
      if (spiAck) begin
        spiAck = 1'b0;
      end else if (spiReq) begin
        logic [7:0] rx;
        logic [8:0] e;
        rx = 8'h00;
        if (fIdx == 0) fOp = spiTx;
        if (fOp == 8'h05 && fIdx == 1) begin
          rx[0] = stuck || (busyLeft > 0);
          if (busyLeft > 0) busyLeft--;
        end
        if (expQ.size() == 0) begin
          check(0, curTag, "unexpected byte", {spiLast, spiTx}, 0);
        end else begin
          e = expQ.pop_front();
          check({spiLast, spiTx} == e, curTag, "byte {last,tx}", {spiLast, spiTx}, e);
        end
        if (spiLast) begin
          fIdx = 0;
          if (fOp == 8'h02 || fOp == 8'hAD || fOp == 8'h04) begin
            busyLeft = 2;
            if (stuckMode == 2) stuck = 1;
          end
        end else begin
          fIdx++;
        end
        spiRx = rx;
        spiAck = 1'b1;
        #1;
        if (inReady) advPending = 1;
      end
    end
  end

  task automatic runTest(string tag, int addr, int len, int mode);
    int guard;
    curTag = tag;
    busyLeft = 0; stuckMode = mode; stuck = (mode == 1); fIdx = 0;
    k = 0; advPending = 0; inByte = dataAt(0); inValid = 1'b1;
    buildExp(addr, len, mode);
    @(negedge clk);
    startAddr = 24'(addr); startLen = 16'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    check(done == 1'b1, tag, "done reached", done, 1);
    check(error == expErr, tag, "error flag", error, expErr);
    check(byteCount == 16'(expCount), tag, "byte count", byteCount, expCount);
    check(busy == 1'b0, tag, "busy at done", busy, 0);
    repeat (6) @(negedge clk);
    check(expQ.size() == 0, tag, "bytes left unsent", expQ.size(), 0);
    check(done == 1'b0, "R9", "done pulse width", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    curTag = "R9";
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && error == 0, "R9", "reset status", {busy, done, error}, 0);
    check(spiReq == 0, "R10", "reset request", spiReq, 0);
    check(byteCount == 0, "R9", "reset count", byteCount, 0);

    runTest("R1", 24'h000100, 0, 0);   // zero length: poll only
    runTest("R4", 24'h001000, 6, 0);   // aligned pairs only
    runTest("R3", 24'h0010FF, 4, 0);   // odd head, pair across byte boundary, tail
    runTest("R6", 24'h002001, 1, 0);   // odd head only, then disable
    runTest("R7", 24'h003000, 1, 0);   // single trailing byte after disable
    runTest("R5", 24'h0040FD, 6, 0);   // head, two pairs, tail
    runTest("R8", 24'h005000, 4, 1);   // device never idle
    runTest("R8", 24'h006003, 5, 2);   // busy forever after the head byte
    runTest("R2", 24'h007002, 2, 0);   // write enable then one pair
    runTest("R10", 24'h0080FF, 8, 0);  // long odd run

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule